// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block sits beside a processor core and decides which of several interrupt sources is offered to the core. Each source carries a priority level. Most sources take a programmable level and an enable bit. A parameter can instead mark a source as a debug-class source, as a low-priority software trap with a fixed level, or as non-maskable. The block holds the core's current priority level. A source is offered only if its level reaches that current level, and the highest-level eligible source wins.

When the core accepts the offered request, the current level rises to one above the accepted level, so a request of the same or lower priority cannot pre-empt the handler. Level 3 saturates, and the low-priority software trap leaves the level where it was. The level that was in force before acceptance goes onto a small stack. A return-from-interrupt pulse pops that stack and restores the level, so the nesting is enforced in hardware. Software may also write the current level directly, for example to lower it from its reset value of 3.

The offer is registered. Any change of the current level (an accept, a return or a write) withdraws the offer for one cycle, and the next offer is judged against the new level.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset the current level is 3, no request is offered, and the saved-level stack is empty.
- R2: An ordinary source uses its 2-bit configured level, and a configured value of 3 is treated as level 2. An ordinary source whose enable bit is 0 is never offered.
- R3: A debug-class source uses its 2-bit configured level, and a configured value of 0 is treated as level 1.
- R4: A maskable source is eligible only when its effective level is greater than or equal to the current level. A non-maskable source has fixed level 3 and is eligible whenever it requests, regardless of enable, global mask and current level.
- R5: The offer appears one clock after the inputs that cause it. Among eligible sources it names the highest effective level, and the lower source index wins a tie. `irq_vec` carries the source index and `irq_lvl` carries the effective level.
- R6: An accept is `irq_ack` high while `irq_valid` is high. On an accept the current level becomes the accepted level plus 1, saturating at 3. The previous level is pushed onto the stack, and the offer drops in the following cycle. `irq_ack` without an offer is ignored.
- R7: The low-priority software trap source has fixed level 0 and ignores its enable bit. Accepting it leaves the current level unchanged, but it still pushes an entry that a later return pops.
- R8: A return (`irq_rti` high) pops the stack and restores the popped level. A return while the stack is empty changes nothing.
- R9: While `gbl_mask` is high, no maskable source is offered and the current level is not altered. Non-maskable sources are still offered.
- R10: While the stack holds its full number of entries (4 by default), no request is offered.
- R11: An accept and a return in the same cycle first restore the popped level and then apply the accept. The stack depth stays the same, and the entry left on top equals the level that was restored.
- R12: A level write (`lvl_wr`) loads `lvl_wdata` into the current level only in a cycle with neither an accept nor an effective return. Otherwise the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Request line per source |
| src_en | input | N_SRC | Enable per programmable source |
| src_cfg | input | 2*N_SRC | Configured level, 2 bits per source, source i at bits 2i+1:2i |
| gbl_mask | input | 1 | Masks all maskable sources |
| lvl_wr | input | 1 | Write strobe for the current level |
| lvl_wdata | input | 2 | Level value to write |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_rti | input | 1 | Core returns from a handler |
| irq_valid | output | 1 | A request is offered |
| irq_vec | output | clog2(N_SRC) | Index of the offered source |
| irq_lvl | output | 2 | Effective level of the offered source |
| cur_lvl | output | 2 | Current core priority level |

## Verification
Accept and return can fall in the same cycle, as happens when a handler ends just as the next request is taken. The bench builds a one-deep stack by taking a level-1 request, then raises a level-2 request and pulses `irq_ack` and `irq_rti` together on the edge where that request is offered. The result is judged by the new current level, which must be 3, and by one later return, which must restore the original level 0 and leave the stack empty, as a further ignored return shows. A level write that coincides with a return is provoked the same way and must lose to the return.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP = 2'd3;
  localparam lvl_t LVL_ORD_MAX = 2'd2;
  localparam lvl_t LVL_DBG_MIN = 2'd1;

  function automatic lvl_t raised_level(lvl_t l);
    return (l == LVL_TOP) ? LVL_TOP : l + 2'd1;
  endfunction
endpackage

// File: rtl/irq_src_qual.sv
module irq_src_qual
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] DBG_MASK = '0,
  parameter logic [N_SRC-1:0] SWL_MASK = '0,
  parameter logic [N_SRC-1:0] NMI_MASK = '0
) (
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC-1:0]       en,
  input  logic [2*N_SRC-1:0]     cfg,
  input  logic                   gmask,
  input  lvl_t                   cur,
  output logic [N_SRC-1:0]       elig,
  output logic [2*N_SRC-1:0]     eff
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    lvl_t raw;
    lvl_t lv;
    assign raw = cfg[2*i +: 2];
    if (NMI_MASK[i]) begin : g_nmi
      assign lv = LVL_TOP;
      assign elig[i] = req[i];
    end else if (SWL_MASK[i]) begin : g_swl
      assign lv = '0;
      assign elig[i] = req[i] && !gmask && (lv >= cur);
    end else if (DBG_MASK[i]) begin : g_dbg
      assign lv = (raw < LVL_DBG_MIN) ? LVL_DBG_MIN : raw;
      assign elig[i] = req[i] && en[i] && !gmask && (lv >= cur);
    end else begin : g_ord
      assign lv = (raw > LVL_ORD_MAX) ? LVL_ORD_MAX : raw;
      assign elig[i] = req[i] && en[i] && !gmask && (lv >= cur);
    end
    assign eff[2*i +: 2] = lv;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]   elig,
  input  logic [2*N_SRC-1:0] eff,
  output logic               any,
  output logic [VEC_W-1:0]   vec,
  output lvl_t               lvl
);
  always_comb begin
    any = 1'b0;
    vec = '0;
    lvl = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!any || (eff[2*i +: 2] > lvl))) begin
        any = 1'b1;
        vec = VEC_W'(i);
        lvl = eff[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int ADR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  lvl_t wdata,
  output lvl_t top,
  output logic empty,
  output logic full
);
  lvl_t mem [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] top_ptr;
  logic [ADR_W-1:0] top_adr;
  logic [ADR_W-1:0] wr_adr;
  logic             do_pop;
  logic             do_push;

  assign empty   = (ptr == '0);
  assign full    = (ptr == PTR_W'(DEPTH));
  assign top_ptr = ptr - 1'b1;
  assign top_adr = top_ptr[ADR_W-1:0];
  assign top     = mem[top_adr];
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign wr_adr  = do_pop ? top_adr : ptr[ADR_W-1:0];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_adr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (do_push && !do_pop) ptr <= ptr + 1'b1;
    else if (do_pop && !do_push) ptr <= ptr - 1'b1;
  end
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int STK_DEPTH = 4,
  parameter logic [N_SRC-1:0] DBG_MASK = 8'h40,
  parameter logic [N_SRC-1:0] SWL_MASK = 8'h20,
  parameter logic [N_SRC-1:0] NMI_MASK = 8'h80,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   src_req,
  input  logic [N_SRC-1:0]   src_en,
  input  logic [2*N_SRC-1:0] src_cfg,
  input  logic               gbl_mask,
  input  logic               lvl_wr,
  input  logic [1:0]         lvl_wdata,
  input  logic               irq_ack,
  input  logic               irq_rti,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [1:0]         irq_lvl,
  output logic [1:0]         cur_lvl
);
  localparam logic [N_SRC-1:0] SWL_V = SWL_MASK;

  logic [N_SRC-1:0]   elig;
  logic [2*N_SRC-1:0] eff;
  logic               pick_any;
  logic [VEC_W-1:0]   pick_vec;
  lvl_t               pick_lvl;
  logic               held_swl;
  lvl_t               stk_top;
  logic               stk_empty;
  logic               stk_full;
  logic               take_ack;
  logic               take_rti;
  lvl_t               base_lvl;

  irq_src_qual #(
    .N_SRC(N_SRC), .DBG_MASK(DBG_MASK), .SWL_MASK(SWL_MASK), .NMI_MASK(NMI_MASK)
  ) u_qual (
    .req(src_req), .en(src_en), .cfg(src_cfg), .gmask(gbl_mask),
    .cur(cur_lvl), .elig(elig), .eff(eff)
  );

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .elig(elig), .eff(eff), .any(pick_any), .vec(pick_vec), .lvl(pick_lvl)
  );

  assign take_ack = irq_ack && irq_valid;
  assign take_rti = irq_rti && !stk_empty;
  assign base_lvl = take_rti ? stk_top : cur_lvl;

  irq_lvl_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(take_ack), .pop(take_rti),
    .wdata(base_lvl), .top(stk_top), .empty(stk_empty), .full(stk_full)
  );

  always_ff @(posedge clk) begin
    if (rst) cur_lvl <= LVL_TOP;
    else if (take_ack) cur_lvl <= held_swl ? base_lvl : raised_level(irq_lvl);
    else if (take_rti) cur_lvl <= stk_top;
    else if (lvl_wr) cur_lvl <= lvl_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      irq_lvl   <= '0;
      held_swl  <= 1'b0;
    end else begin
      irq_valid <= pick_any && !stk_full && !take_ack && !take_rti && !lvl_wr;
      irq_vec   <= pick_vec;
      irq_lvl   <= pick_lvl;
      held_swl  <= SWL_V[pick_vec];
    end
  end
endmodule

// File: rtl/irq_nest_arb_chk.sv
module irq_nest_arb_chk #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] NMI_MASK = '0,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_ack,
  input logic             irq_rti,
  input logic             lvl_wr,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vec,
  input logic [1:0]       irq_lvl,
  input logic [1:0]       cur_lvl,
  input logic             held_swl,
  input logic             stk_empty,
  input logic             stk_full
);
  localparam logic [N_SRC-1:0] NMI_V = NMI_MASK;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cur_lvl == 2'd3 && !irq_valid && stk_empty));

  assert_offer_eligible_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !NMI_V[irq_vec]) |-> (irq_lvl >= cur_lvl));

  assert_accept_raise_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_valid && !held_swl && irq_lvl != 2'd3) |=>
      (cur_lvl == $past(irq_lvl) + 2'd1));

  assert_accept_saturate_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_valid && irq_lvl == 2'd3) |=> (cur_lvl == 2'd3));

  assert_accept_withdraw_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_valid) |=> !irq_valid);

  assert_empty_return_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_rti && stk_empty && !(irq_ack && irq_valid) && !lvl_wr) |=> $stable(cur_lvl));

  assert_full_no_offer_R10: assert property (@(posedge clk) disable iff (rst)
    stk_full |-> !irq_valid);
endmodule

bind irq_nest_arb irq_nest_arb_chk #(.N_SRC(N_SRC), .NMI_MASK(NMI_MASK)) u_chk (
  .clk(clk), .rst(rst), .irq_ack(irq_ack), .irq_rti(irq_rti), .lvl_wr(lvl_wr),
  .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_lvl(irq_lvl), .cur_lvl(cur_lvl),
  .held_swl(held_swl), .stk_empty(stk_empty), .stk_full(stk_full)
);

// File: tb/test_irq_nest_arb.sv
module test_irq_nest_arb;
  localparam int N = 6;
  // src0..2 ordinary, src3 debug, src4 software trap, src5 non-maskable
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   src_req = '0;
  logic [N-1:0]   src_en = '1;
  logic [2*N-1:0] src_cfg = '0;
  logic gbl_mask = 1'b0, lvl_wr = 1'b0, irq_ack = 1'b0, irq_rti = 1'b0;
  logic [1:0] lvl_wdata = '0;
  logic irq_valid;
  logic [2:0] irq_vec;
  logic [1:0] irq_lvl, cur_lvl;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  irq_nest_arb #(
    .N_SRC(N), .STK_DEPTH(4),
    .DBG_MASK(6'b001000), .SWL_MASK(6'b010000), .NMI_MASK(6'b100000)
  ) i_irq_nest_arb (
    .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en), .src_cfg(src_cfg),
    .gbl_mask(gbl_mask), .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
    .irq_ack(irq_ack), .irq_rti(irq_rti), .irq_valid(irq_valid),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl), .cur_lvl(cur_lvl)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int offer_code();
    return {irq_valid, irq_vec, irq_lvl};
  endfunction

  function automatic int model(logic [N-1:0] req, logic [N-1:0] en,
                               logic [2*N-1:0] cfg, int cur, bit gm);
    int best = -1, bl = 0;
    for (int i = 0; i < N; i++) begin
      int e;
      bit ok;
      int raw = int'(cfg[2*i +: 2]);
      if (i == 5) begin e = 3; ok = req[i]; end
      else if (i == 4) begin e = 0; ok = req[i] && !gm && (e >= cur); end
      else begin
        if (i == 3) e = (raw == 0) ? 1 : raw;
        else e = (raw == 3) ? 2 : raw;
        ok = req[i] && en[i] && !gm && (e >= cur);
      end
      if (ok && (best < 0 || e > bl)) begin best = i; bl = e; end
    end
    if (best < 0) return 0;
    return (1 << 5) | (best << 2) | bl;
  endfunction

  task automatic set_cur(int c);
    lvl_wr = 1'b1; lvl_wdata = 2'(c);
    @(negedge clk);
    lvl_wr = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic pulse_rti();
    irq_rti = 1'b1;
    @(negedge clk);
    irq_rti = 1'b0;
  endtask

  initial begin
    #(150000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 cur_lvl", int'(cur_lvl), 3);
    check("R1 irq_valid", int'(irq_valid), 0);
    pulse_rti();
    check("R1 empty stack return", int'(cur_lvl), 3);

    // R2 R3 R4 R5 R7: exhaustive sweep of requests, levels and current level
    for (int c = 0; c < 4; c++) begin
      set_cur(c);
      check("R12 level write", int'(cur_lvl), c);
      for (int r = 0; r < 64; r++) begin
        for (int g = 0; g < 256; g++) begin
          src_req = 6'(r);
          src_cfg = {4'b0000, 8'(g)};
          @(negedge clk);
          check("R5 sweep offer", offer_code(), model(6'(r), '1, src_cfg, c, 1'b0));
        end
      end
    end
    src_req = '0;

    // R6: accept raises level, saturates at 3
    set_cur(0);
    src_cfg = 12'b00_00_11_00_10_01;  // src0=1, src1=2, src3 cfg=3
    src_req = 6'b000001;
    @(negedge clk);
    check("R5 offer src0", offer_code(), (1 << 5) | (0 << 2) | 1);
    pulse_ack();
    check("R6 raise to 2", int'(cur_lvl), 2);
    check("R6 offer withdrawn", int'(irq_valid), 0);
    src_req = 6'b000011;
    @(negedge clk);
    check("R4 lower blocked", offer_code(), (1 << 5) | (1 << 2) | 2);
    pulse_ack();
    check("R6 raise to 3", int'(cur_lvl), 3);
    src_req = 6'b001000;
    @(negedge clk);
    check("R3 debug level 3", offer_code(), (1 << 5) | (3 << 2) | 3);
    pulse_ack();
    check("R6 saturate", int'(cur_lvl), 3);
    src_req = '0;
    // R8: unwind
    pulse_rti();
    check("R8 pop 1", int'(cur_lvl), 3);
    pulse_rti();
    check("R8 pop 2", int'(cur_lvl), 2);
    pulse_rti();
    check("R8 pop 3", int'(cur_lvl), 0);
    pulse_rti();
    check("R8 empty ignored", int'(cur_lvl), 0);

    // R7: software trap keeps level but pushes
    src_req = 6'b010000;
    @(negedge clk);
    check("R7 offer trap", offer_code(), (1 << 5) | (4 << 2) | 0);
    pulse_ack();
    src_req = '0;
    check("R7 level kept", int'(cur_lvl), 0);
    set_cur(2);
    pulse_rti();
    check("R7 push popped", int'(cur_lvl), 0);

    // R9: global mask
    gbl_mask = 1'b1;
    src_req = 6'b000001;
    @(negedge clk);
    check("R9 masked", int'(irq_valid), 0);
    src_req = 6'b100001;
    @(negedge clk);
    check("R9 nmi passes", offer_code(), (1 << 5) | (5 << 2) | 3);
    check("R9 level kept", int'(cur_lvl), 0);
    gbl_mask = 1'b0;

    // R2: disabled ordinary source
    src_en = 6'b111110;
    src_req = 6'b000001;
    @(negedge clk);
    check("R2 disabled", int'(irq_valid), 0);
    src_en = '1;

    // R10: stack full blocks offers
    src_req = 6'b100000;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10 nmi offered", int'(irq_valid), 1);
      pulse_ack();
    end
    @(negedge clk);
    @(negedge clk);
    check("R10 full blocks", int'(irq_valid), 0);
    src_req = '0;
    for (int k = 0; k < 4; k++) pulse_rti();
    check("R10 unwound", int'(cur_lvl), 0);

    // R11: accept and return together
    src_req = 6'b000001;
    @(negedge clk);
    pulse_ack();
    check("R11 setup", int'(cur_lvl), 2);
    src_req = 6'b000011;
    @(negedge clk);
    check("R11 offer", offer_code(), (1 << 5) | (1 << 2) | 2);
    irq_ack = 1'b1; irq_rti = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0; irq_rti = 1'b0;
    src_req = '0;
    check("R11 new level", int'(cur_lvl), 3);
    // R12: write loses to a return
    irq_rti = 1'b1; lvl_wr = 1'b1; lvl_wdata = 2'd2;
    @(negedge clk);
    irq_rti = 1'b0; lvl_wr = 1'b0;
    check("R11 R12 restored top", int'(cur_lvl), 0);
    pulse_rti();
    check("R11 depth kept", int'(cur_lvl), 0);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R6 ack without offer", int'(cur_lvl), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule